// File: doc/BRIEF.md
# I2C Controller Raw Interrupt Flags

This block keeps the three raw interrupt flags of an I2C controller: access ready, no-acknowledge and arbitration lost. It watches single-cycle event pulses from the bit engine and the current operating mode (master or slave, transmit or receive, stop-after-transfer). From these it decides when each flag rises. Software clears a flag by writing 1 to its bit. A combined interrupt line is raised whenever an enabled flag is set.

The access-ready condition depends on the mode. A master that ends with a stop waits for the data count to hit zero. A master that does not stop waits for the count to pass zero. A slave waits for a stop or repeated start from the external master. Every receive mode also needs the receive FIFO to be empty. A no-acknowledge or a lost arbitration pushes the controller out of master mode. For that, the block pulses one-cycle strobes that clear the master and stop bits of the control register.

Top module: `i2c_irq_flags`

## Requirements
- R1: After reset, `flags` is 3'b000, `irq` is 0 and both control-clear strobes are 0.
- R2: Flag positions are access ready at bit 2, no-acknowledge at bit 1 and arbitration lost at bit 0. A cycle with `wr_en` high clears every flag whose `wr_data` bit is 1. A 0 bit in `wr_data` leaves its flag unchanged.
- R3: If a set event and a write-1 clear hit the same flag in the same cycle, the flag is 1 after that edge.
- R4: Master transmit with stop-after-transfer set: access ready rises one cycle after `cnt_zero_evt`. `cnt_pass_evt` does not raise it.
- R5: Master receive with stop-after-transfer set: access ready rises on `cnt_zero_evt` only while `rxf_empty` is 1.
- R6: Master with stop-after-transfer clear: access ready rises on `cnt_pass_evt`. `cnt_zero_evt` does not raise it. In receive it also needs `rxf_empty`.
- R7: Slave mode: access ready rises on `slv_stop_evt`. In receive it also needs `rxf_empty`. Data count events have no effect.
- R8: `nack_evt` sets flag bit 1. In the same cycle the flag rises, `clr_master` and `clr_stop` pulse high for exactly one cycle.
- R9: `arb_lost_evt` sets flag bit 0 and pulses the control-clear strobes only while `is_master` is 1. In slave mode it has no effect.
- R10: `start_req` while `bus_busy` is 1 sets flag bit 0 and pulses the strobes. With `bus_busy` 0 it has no effect.
- R11: `irq` is high exactly when some flag bit and its `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = master mode, 0 = slave |
| is_tx | input | 1 | 1 = transmit, 0 = receive |
| stop_after | input | 1 | Master issues stop at end of transfer |
| bus_busy | input | 1 | Bus currently busy |
| cnt_zero_evt | input | 1 | Pulse: data count reached zero |
| cnt_pass_evt | input | 1 | Pulse: data count passed zero |
| rxf_empty | input | 1 | Receive FIFO empty level |
| slv_stop_evt | input | 1 | Pulse: stop or repeated start seen as slave |
| nack_evt | input | 1 | Pulse: no-acknowledge detected |
| arb_lost_evt | input | 1 | Pulse: arbitration lost in address phase |
| start_req | input | 1 | Pulse: master start attempted |
| wr_en | input | 1 | Software write strobe to the status word |
| wr_data | input | 3 | Write-1-to-clear mask |
| irq_en | input | 3 | Per-flag interrupt enable |
| flags | output | 3 | Raw flag word |
| irq | output | 1 | Combined interrupt |
| clr_master | output | 1 | One-cycle strobe to clear the master bit |
| clr_stop | output | 1 | One-cycle strobe to clear the stop bit |

## Verification
The bound checker tests several rules on every cycle. A flag never rises without a set pulse. A write-1 clear with no competing set drops its flag, and any set pulse wins over a clear. Each error set brings exactly one strobe cycle, and there are never strobes without one. A slave-mode arbitration event without a start attempt raises nothing. The interrupt stays low when all flags are zero. Only the bench's scenarios show that the mode-dependent access-ready decode matches the six mode cases, that the FIFO-empty gating applies only to receive, and that masking by `irq_en` leaves the interrupt low even when a flag is set.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int FLAG_W  = 3;
  localparam int RDY_IDX = 2;
  localparam int NAK_IDX = 1;
  localparam int ARB_IDX = 0;

  typedef struct packed {
    logic master;
    logic tx;
    logic stop_after;
  } mode_t;

  // Trigger for access ready: pick the event for the mode,
  // then gate receive modes with an empty receive FIFO.
  function automatic logic rdy_cond(mode_t m, logic cz, logic cp,
                                    logic empty, logic sstop);
    logic ev;
    if (!m.master)        ev = sstop;
    else if (m.stop_after) ev = cz;
    else                  ev = cp;
    return ev & (m.tx | empty);
  endfunction

  // Error trigger for arbitration loss
  function automatic logic arb_cond(logic master, logic arb_evt,
                                    logic start, logic busy);
    return (master & arb_evt) | (start & busy);
  endfunction
endpackage

// File: rtl/i2c_rdy_detect.sv
module i2c_rdy_detect
  import i2c_irq_pkg::*;
(
  input  mode_t mode,
  input  logic  cnt_zero_evt,
  input  logic  cnt_pass_evt,
  input  logic  rxf_empty,
  input  logic  slv_stop_evt,
  output logic  rdy_set
);
  always_comb rdy_set = rdy_cond(mode, cnt_zero_evt, cnt_pass_evt,
                                 rxf_empty, slv_stop_evt);
endmodule

// File: rtl/i2c_err_detect.sv
module i2c_err_detect
  import i2c_irq_pkg::*;
(
  input  logic is_master,
  input  logic nack_evt,
  input  logic arb_lost_evt,
  input  logic start_req,
  input  logic bus_busy,
  output logic nak_set,
  output logic arb_set,
  output logic err_set
);
  always_comb begin
    nak_set = nack_evt;
    arb_set = arb_cond(is_master, arb_lost_evt, start_req, bus_busy);
    err_set = nak_set | arb_set;
  end
endmodule

// File: rtl/i2c_w1c_flag.sv
module i2c_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_ctrl_strobe.sv
module i2c_ctrl_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic err_set,
  output logic clr_master,
  output logic clr_stop
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_master <= 1'b0;
      clr_stop   <= 1'b0;
    end else begin
      clr_master <= err_set;
      clr_stop   <= err_set;
    end
  end
endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              is_tx,
  input  logic              stop_after,
  input  logic              bus_busy,
  input  logic              cnt_zero_evt,
  input  logic              cnt_pass_evt,
  input  logic              rxf_empty,
  input  logic              slv_stop_evt,
  input  logic              nack_evt,
  input  logic              arb_lost_evt,
  input  logic              start_req,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic              clr_master,
  output logic              clr_stop
);
  mode_t             mode;
  logic              rdy_set;
  logic              nak_set;
  logic              arb_set;
  logic              err_set;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;

  always_comb begin
    mode.master     = is_master;
    mode.tx         = is_tx;
    mode.stop_after = stop_after;
  end

  i2c_rdy_detect u_rdy (
    .mode         (mode),
    .cnt_zero_evt (cnt_zero_evt),
    .cnt_pass_evt (cnt_pass_evt),
    .rxf_empty    (rxf_empty),
    .slv_stop_evt (slv_stop_evt),
    .rdy_set      (rdy_set)
  );

  i2c_err_detect u_err (
    .is_master    (is_master),
    .nack_evt     (nack_evt),
    .arb_lost_evt (arb_lost_evt),
    .start_req    (start_req),
    .bus_busy     (bus_busy),
    .nak_set      (nak_set),
    .arb_set      (arb_set),
    .err_set      (err_set)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[RDY_IDX] = rdy_set;
    set_vec[NAK_IDX] = nak_set;
    set_vec[ARB_IDX] = arb_set;
    clr_vec          = wr_en ? wr_data : '0;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    i2c_w1c_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_vec[i]),
      .clr   (clr_vec[i]),
      .q     (flags[i])
    );
  end

  i2c_ctrl_strobe u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_set    (err_set),
    .clr_master (clr_master),
    .clr_stop   (clr_stop)
  );

  always_comb irq = |(flags & irq_en);
endmodule

// File: rtl/i2c_irq_flags_chk.sv
module i2c_irq_flags_chk
  import i2c_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              is_master,
  input logic              start_req,
  input logic              wr_en,
  input logic [FLAG_W-1:0] wr_data,
  input logic [FLAG_W-1:0] set_vec,
  input logic              arb_set,
  input logic              err_set,
  input logic [FLAG_W-1:0] flags,
  input logic              irq,
  input logic              clr_master,
  input logic              clr_stop
);
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags & $past(wr_data & ~set_vec)) == '0));

  // R2
  no_rise_without_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

  // R8
  strobe_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> (clr_master && clr_stop));

  // R8
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_set |=> (!clr_master && !clr_stop));

  // R9
  slave_arb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !start_req) |-> !arb_set);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

bind i2c_irq_flags i2c_irq_flags_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .is_master  (is_master),
  .start_req  (start_req),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .set_vec    (set_vec),
  .arb_set    (arb_set),
  .err_set    (err_set),
  .flags      (flags),
  .irq        (irq),
  .clr_master (clr_master),
  .clr_stop   (clr_stop)
);

// File: tb/i2c_irq_flags_bench.sv
`timescale 1ns/1ps
module i2c_irq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_master = 0, is_tx = 0, stop_after = 0, bus_busy = 0;
  logic       cnt_zero_evt = 0, cnt_pass_evt = 0, rxf_empty = 0;
  logic       slv_stop_evt = 0, nack_evt = 0, arb_lost_evt = 0, start_req = 0;
  logic       wr_en = 0;
  logic [2:0] wr_data = '0;
  logic [2:0] irq_en = '0;
  logic [2:0] flags;
  logic       irq, clr_master, clr_stop;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_irq_flags u_i2c_irq_flags (.*);

  // {master, tx, stop_after, cnt_zero, cnt_pass, rx_empty, slave_stop, expected ready}
  localparam logic [7:0] VEC [0:11] = '{
    8'b11110001, 8'b11101000,              // R4
    8'b10110101, 8'b10110000,              // R5
    8'b11001001, 8'b11010000,              // R6
    8'b10001101, 8'b10001000,              // R6
    8'b01000011, 8'b01010000,              // R7
    8'b00000111, 8'b00000010               // R7
  };

  function automatic string vec_req(int i);
    if (i < 2) return "R4";
    if (i < 4) return "R5";
    if (i < 8) return "R6";
    return "R7";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 3'b111;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags, 3'b000);
    chk("R1 strobes", {clr_master, clr_stop}, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", irq, 0);

    // Vector table: access-ready decode per mode
    for (int i = 0; i < 12; i++) begin
      clear_all();
      {is_master, is_tx, stop_after, cnt_zero_evt, cnt_pass_evt,
       rxf_empty, slv_stop_evt} = VEC[i][7:1];
      @(negedge clk);
      cnt_zero_evt = 0; cnt_pass_evt = 0; slv_stop_evt = 0; rxf_empty = 0;
      chk(vec_req(i), flags, {VEC[i][0], 2'b00});
    end

    // R8 nack sets bit 1 and strobes one cycle
    clear_all();
    is_master = 1; is_tx = 1; stop_after = 1;
    nack_evt = 1;
    @(negedge clk);
    nack_evt = 0;
    chk("R8 flag", flags, 3'b010);
    chk("R8 strobe", {clr_master, clr_stop}, 2'b11);
    @(negedge clk);
    chk("R8 strobe width", {clr_master, clr_stop}, 2'b00);

    // R2 writing zeros leaves flag; writing one at bit 1 clears it
    wr_en = 1; wr_data = 3'b101;
    @(negedge clk);
    chk("R2 zero no effect", flags, 3'b010);
    wr_data = 3'b010;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
    chk("R2 clear", flags, 3'b000);

    // R3 set and clear same cycle
    nack_evt = 1;
    @(negedge clk);
    nack_evt = 1; wr_en = 1; wr_data = 3'b010;
    @(negedge clk);
    nack_evt = 0; wr_en = 0; wr_data = '0;
    chk("R3 set wins", flags, 3'b010);
    clear_all();

    // R9 arbitration lost in master
    arb_lost_evt = 1;
    @(negedge clk);
    arb_lost_evt = 0;
    chk("R9 master arb", flags, 3'b001);
    chk("R9 strobe", clr_master, 1);
    clear_all();

    // R9 ignored in slave
    is_master = 0;
    arb_lost_evt = 1;
    @(negedge clk);
    arb_lost_evt = 0;
    chk("R9 slave ignored", flags, 3'b000);
    chk("R9 no strobe", clr_master, 0);

    // R10 start while busy / idle
    is_master = 1; bus_busy = 0; start_req = 1;
    @(negedge clk);
    start_req = 0;
    chk("R10 idle start", flags, 3'b000);
    bus_busy = 1; start_req = 1;
    @(negedge clk);
    start_req = 0; bus_busy = 0;
    chk("R10 busy start", flags, 3'b001);
    chk("R10 strobe", clr_stop, 1);

    // R11 interrupt masking
    irq_en = 3'b110;
    #1 chk("R11 masked", irq, 0);
    irq_en = 3'b001;
    #1 chk("R11 enabled", irq, 1);
    clear_all();
    chk("R11 cleared", irq, 0);

    @(negedge clk);
    finish_run();
  end
endmodule